// File: doc/BRIEF.md
# Descriptor Table Register Store Unit

This execution block carries out the two instructions that copy a descriptor table register (the global table or the interrupt table) out to memory. For each instruction it receives the decoded opcode bytes, the ModRM mode and reg fields, the operand size, the processor mode, the current privilege level and the alignment-check enable. It also receives a short description of the segment used for the access, the effective address and the present contents of both table registers. When it accepts an instruction, it captures all of these inputs.

From the captured inputs it works out whether the instruction faults. If it does, the block reports a fault code and writes nothing. If it does not, the block builds a six-byte image of the chosen register: a 16-bit limit followed by the base. In the 16-bit operand form only 24 bits of the base are kept and the top byte is zero. It sends the image one byte per handshake over a byte-wide write port, in ascending address order, and then pulses done. Paging and segment address translation are handled elsewhere.

Top module: `dtr_store_unit`

## Requirements
- R1: An instruction is valid only when `opc0` is 0x0F, `opc1` is 0x01 and `modrm_reg` is 0 or 1. A reg value of 0 stores the global table register and a value of 1 stores the interrupt table register. Any other opcode bytes or reg value gives fault code 1 (invalid opcode).
- R2: Image bytes 0 and 1, at `eff_addr` and `eff_addr`+1, hold the 16-bit limit of the selected register, with the low byte first.
- R3: When `op32` is 1, image bytes 2 to 5 hold the 32-bit base, with the low byte first.
- R4: When `op32` is 0, image bytes 2 to 4 hold base bits 23:0, with the low byte first, and byte 5 is written as 0x00.
- R5: A register destination (`modrm_mod` = 2'b11) gives fault code 1 in every processor mode.
- R6: `cpu_mode` is encoded as 0 = real, 1 = protected, 2 = virtual-8086, and 3 is handled as protected. In protected mode, fault code 2 (general protection) is raised when `seg_null` is set on a segment that is not the stack segment, or when `seg_wr` is 0. Neither check is made in real or virtual-8086 mode.
- R7: In every mode, if `eff_addr`+5 is greater than `seg_limit` (computed without wrap-around), the block raises fault code 3 (stack fault) when `seg_is_ss` is 1, and fault code 2 otherwise. If `eff_addr`+5 equals `seg_limit`, no fault is raised.
- R8: When `eff_addr` bit 0 is 1, fault code 4 (alignment) is raised in the following cases: in protected mode when `cpl` is 3 and `ac_en` is 1; in virtual-8086 mode whenever `ac_en` is 1. It is never raised in real mode.
- R9: When more than one fault applies, the block reports the first of these: invalid opcode, then the protected-mode segment checks, then the limit check, then alignment. A faulting instruction issues no write. It ends with one cycle in which `done` and `fault` are both high and `fault_code` carries the code. `fault_code` is 0 whenever `fault` is low.
- R10: A `start` is accepted only while `busy` is low, and every input is captured at that clock edge. A `start` while busy, and any change to an input after acceptance, has no effect on the instruction in progress.
- R11: A store that does not fault writes six bytes at addresses `eff_addr` to `eff_addr`+5, in ascending order, one byte per cycle in which `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values.
- R12: In the cycle after the last byte is accepted, `done` is high for exactly one cycle with `fault` low. In the cycle after that, `busy` is low.
- R13: While `rst_n` is low, `busy`, `mem_valid`, `done` and `fault` are low and `fault_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to execute one instruction |
| opc0 | input | 8 | First opcode byte |
| opc1 | input | 8 | Second opcode byte |
| modrm_mod | input | 2 | ModRM mode field |
| modrm_reg | input | 3 | ModRM reg field |
| op32 | input | 1 | 1 for 32-bit operand size, 0 for 16-bit |
| cpu_mode | input | 2 | Processor mode |
| cpl | input | 2 | Current privilege level |
| ac_en | input | 1 | Alignment checking enabled |
| seg_null | input | 1 | Segment selector used for the access is null |
| seg_wr | input | 1 | Segment is writable |
| seg_is_ss | input | 1 | Access goes through the stack segment |
| seg_limit | input | 32 | Segment limit |
| eff_addr | input | 32 | Effective address of the destination |
| gdt_limit | input | 16 | Global table register limit |
| gdt_base | input | 32 | Global table register base |
| idt_limit | input | 16 | Interrupt table register limit |
| idt_base | input | 32 | Interrupt table register base |
| busy | output | 1 | An instruction is in progress |
| mem_valid | output | 1 | A byte write is offered |
| mem_ready | input | 1 | Memory accepts the offered byte |
| mem_addr | output | 32 | Byte write address |
| mem_data | output | 8 | Byte write data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | The completed instruction faulted |
| fault_code | output | 3 | 0 none, 1 invalid opcode, 2 general protection, 3 stack, 4 alignment |

## Verification
The hardest cases to reach are those where several fault conditions apply at once and the priority order decides which code is reported, for example an unaligned address past the stack-segment limit on a non-writable segment at CPL 3. Uniform random inputs almost never produce these. The random generator therefore places the segment limit within a few bytes of the effective address, so the `eff_addr`+5 boundary is crossed about half the time. It also picks the segment flags, the mode and the privilege level from small sets. Directed cases add the exact-limit boundary, the same unaligned address in each mode, and a second `start` plus changed register inputs while a write is stalled by `mem_ready`.

// File: rtl/dtr_pkg.sv
`timescale 1ns/1ps
package dtr_pkg;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_V86  = 2'd2,
    MODE_PRX  = 2'd3
  } cpu_mode_e;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_UD   = 3'd1,
    FLT_GP   = 3'd2,
    FLT_SS   = 3'd3,
    FLT_AC   = 3'd4
  } flt_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WR   = 2'd1,
    SQ_FIN  = 2'd2
  } seq_state_e;

  localparam logic [7:0] ESC_BYTE  = 8'h0F;
  localparam logic [7:0] GRP_BYTE  = 8'h01;
  localparam logic [1:0] MOD_REG   = 2'b11;
  localparam logic [2:0] REG_GLOB  = 3'd0;
  localparam logic [2:0] REG_INTR  = 3'd1;
  localparam int         SHORT_BASE_BYTES = 3;

  function automatic logic is_protected(input logic [1:0] m);
    return (m == MODE_PROT) || (m == MODE_PRX);
  endfunction

endpackage

// File: rtl/dtr_decode.sv
`timescale 1ns/1ps
module dtr_decode
  import dtr_pkg::*;
(
  input  logic [7:0] opc0,
  input  logic [7:0] opc1,
  input  logic [1:0] modrm_mod,
  input  logic [2:0] modrm_reg,
  output logic       sel_idt,
  output logic       bad_enc,
  output logic       reg_dst
);
  logic opc_ok;
  logic reg_ok;

  always_comb begin
    opc_ok  = (opc0 == ESC_BYTE) && (opc1 == GRP_BYTE);
    reg_ok  = (modrm_reg == REG_GLOB) || (modrm_reg == REG_INTR);
    sel_idt = (modrm_reg == REG_INTR);
    bad_enc = !(opc_ok && reg_ok);
    reg_dst = (modrm_mod == MOD_REG);
  end
endmodule

// File: rtl/dtr_fault_check.sv
`timescale 1ns/1ps
module dtr_fault_check
  import dtr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IMG_BYTES = 6
) (
  input  logic              bad_enc,
  input  logic              reg_dst,
  input  logic [1:0]        cpu_mode,
  input  logic [1:0]        cpl,
  input  logic              ac_en,
  input  logic              seg_null,
  input  logic              seg_wr,
  input  logic              seg_is_ss,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic [ADDR_W-1:0] eff_addr,
  output logic              ud_hit,
  output logic              seg_hit,
  output logic              lim_hit,
  output logic              ac_hit,
  output flt_e              code
);
  localparam int SPAN = IMG_BYTES - 1;

  function automatic logic span_over(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] lim);
    logic [ADDR_W:0] last_byte;
    last_byte = {1'b0, a} + (ADDR_W+1)'(SPAN);
    return last_byte > {1'b0, lim};
  endfunction

  function automatic logic align_trap(input logic [1:0] m, input logic [1:0] pl,
                                      input logic en, input logic odd);
    logic armed;
    case (m)
      MODE_REAL: armed = 1'b0;
      MODE_V86:  armed = en;
      default:   armed = en && (pl == 2'd3);
    endcase
    return armed && odd;
  endfunction

  always_comb begin
    ud_hit  = bad_enc || reg_dst;
    seg_hit = is_protected(cpu_mode) && ((seg_null && !seg_is_ss) || !seg_wr);
    lim_hit = span_over(eff_addr, seg_limit);
    ac_hit  = align_trap(cpu_mode, cpl, ac_en, eff_addr[0]);
    if (ud_hit)                    code = FLT_UD;
    else if (seg_hit)              code = FLT_GP;
    else if (lim_hit && seg_is_ss) code = FLT_SS;
    else if (lim_hit)              code = FLT_GP;
    else if (ac_hit)               code = FLT_AC;
    else                           code = FLT_NONE;
  end
endmodule

// File: rtl/dtr_image_build.sv
`timescale 1ns/1ps
module dtr_image_build
  import dtr_pkg::*;
#(
  parameter int LIM_W  = 16,
  parameter int BASE_W = 32
) (
  input  logic [LIM_W-1:0]        limit,
  input  logic [BASE_W-1:0]       base,
  input  logic                    op32,
  output logic [LIM_W+BASE_W-1:0] image
);
  localparam int LB = LIM_W / 8;
  localparam int NB = (LIM_W + BASE_W) / 8;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    if (k < LB) begin : g_lim
      assign image[k*8 +: 8] = limit[k*8 +: 8];
    end else if (k - LB < SHORT_BASE_BYTES) begin : g_base_lo
      assign image[k*8 +: 8] = base[(k-LB)*8 +: 8];
    end else begin : g_base_hi
      assign image[k*8 +: 8] = op32 ? base[(k-LB)*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/dtr_byte_seq.sv
`timescale 1ns/1ps
module dtr_byte_seq
  import dtr_pkg::*;
#(
  parameter int IMG_BYTES = 6,
  localparam int IDX_W    = $clog2(IMG_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_write,
  input  logic             go_fault,
  input  logic             mem_ready,
  output logic             busy,
  output logic             mem_valid,
  output logic             done,
  output logic             fault,
  output logic             last_fire,
  output logic [IDX_W-1:0] byte_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(IMG_BYTES - 1);

  seq_state_e st_q;
  logic       flt_q;

  assign busy      = (st_q != SQ_IDLE);
  assign mem_valid = (st_q == SQ_WR);
  assign done      = (st_q == SQ_FIN);
  assign fault     = done && flt_q;
  assign last_fire = mem_valid && mem_ready && (byte_idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      flt_q    <= 1'b0;
      byte_idx <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          byte_idx <= '0;
          if (go_fault) begin
            st_q  <= SQ_FIN;
            flt_q <= 1'b1;
          end else if (go_write) begin
            st_q  <= SQ_WR;
            flt_q <= 1'b0;
          end
        end
        SQ_WR: begin
          if (mem_ready) begin
            if (byte_idx == LAST) st_q <= SQ_FIN;
            else                  byte_idx <= byte_idx + 1'b1;
          end
        end
        default: begin
          st_q     <= SQ_IDLE;
          flt_q    <= 1'b0;
          byte_idx <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/dtr_store_unit.sv
`timescale 1ns/1ps
module dtr_store_unit
  import dtr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 16,
  parameter int BASE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opc0,
  input  logic [7:0]        opc1,
  input  logic [1:0]        modrm_mod,
  input  logic [2:0]        modrm_reg,
  input  logic              op32,
  input  logic [1:0]        cpu_mode,
  input  logic [1:0]        cpl,
  input  logic              ac_en,
  input  logic              seg_null,
  input  logic              seg_wr,
  input  logic              seg_is_ss,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [LIM_W-1:0]  gdt_limit,
  input  logic [BASE_W-1:0] gdt_base,
  input  logic [LIM_W-1:0]  idt_limit,
  input  logic [BASE_W-1:0] idt_base,
  output logic              busy,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_data,
  output logic              done,
  output logic              fault,
  output logic [2:0]        fault_code
);
  localparam int IMG_W     = LIM_W + BASE_W;
  localparam int IMG_BYTES = IMG_W / 8;
  localparam int IDX_W     = $clog2(IMG_BYTES);

  logic             sel_idt, bad_enc, reg_dst;
  logic             ud_hit, seg_hit, lim_hit, ac_hit;
  flt_e             code_d;
  logic [IMG_W-1:0] image_d;
  logic             acc_fire;
  logic             go_write, go_fault, last_fire;
  logic [IDX_W-1:0] byte_idx;

  logic [IMG_W-1:0]  img_q;
  logic [ADDR_W-1:0] addr_q;
  flt_e              code_q;
  logic              op32_q;

  dtr_decode u_dec (
    .opc0(opc0), .opc1(opc1), .modrm_mod(modrm_mod), .modrm_reg(modrm_reg),
    .sel_idt(sel_idt), .bad_enc(bad_enc), .reg_dst(reg_dst)
  );

  dtr_fault_check #(.ADDR_W(ADDR_W), .IMG_BYTES(IMG_BYTES)) u_flt (
    .bad_enc(bad_enc), .reg_dst(reg_dst), .cpu_mode(cpu_mode), .cpl(cpl),
    .ac_en(ac_en), .seg_null(seg_null), .seg_wr(seg_wr), .seg_is_ss(seg_is_ss),
    .seg_limit(seg_limit), .eff_addr(eff_addr),
    .ud_hit(ud_hit), .seg_hit(seg_hit), .lim_hit(lim_hit), .ac_hit(ac_hit),
    .code(code_d)
  );

  dtr_image_build #(.LIM_W(LIM_W), .BASE_W(BASE_W)) u_img (
    .limit(sel_idt ? idt_limit : gdt_limit),
    .base (sel_idt ? idt_base  : gdt_base),
    .op32 (op32),
    .image(image_d)
  );

  assign acc_fire = start && !busy;
  assign go_write = acc_fire && (code_d == FLT_NONE);
  assign go_fault = acc_fire && (code_d != FLT_NONE);

  dtr_byte_seq #(.IMG_BYTES(IMG_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_write(go_write), .go_fault(go_fault),
    .mem_ready(mem_ready), .busy(busy), .mem_valid(mem_valid), .done(done),
    .fault(fault), .last_fire(last_fire), .byte_idx(byte_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img_q  <= '0;
      addr_q <= '0;
      code_q <= FLT_NONE;
      op32_q <= 1'b0;
    end else if (acc_fire) begin
      img_q  <= image_d;
      addr_q <= eff_addr;
      code_q <= code_d;
      op32_q <= op32;
    end
  end

  assign mem_addr   = addr_q + ADDR_W'(byte_idx);
  assign mem_data   = img_q[byte_idx*8 +: 8];
  assign fault_code = fault ? code_q : FLT_NONE;

endmodule

// File: rtl/dtr_store_unit_chk.sv
`timescale 1ns/1ps
module dtr_store_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter int LAST   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        modrm_mod,
  input logic              acc_fire,
  input logic              last_fire,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_data,
  input logic              done,
  input logic              fault,
  input logic [2:0]        fault_code,
  input logic [IDX_W-1:0]  cur_idx,
  input logic              op32_q
);
  AST_REGDST_UD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && modrm_mod == 2'b11 |=> done && fault && fault_code == 3'd1); // R5
  AST_SHORT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !op32_q && cur_idx == IDX_W'(LAST) |-> mem_data == 8'h00); // R4
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)); // R11
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && cur_idx != IDX_W'(LAST) |=> mem_valid && mem_addr == $past(mem_addr) + 1'b1); // R11
  AST_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> cur_idx == '0); // R11
  AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> done && !fault && !mem_valid); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> fault_code == 3'd0); // R9
  AST_FAULT_CODED: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> fault_code != 3'd0 && !mem_valid); // R9
endmodule

bind dtr_store_unit dtr_store_unit_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LAST(IMG_BYTES-1)) u_chk (
  .clk(clk), .rst_n(rst_n), .modrm_mod(modrm_mod), .acc_fire(acc_fire),
  .last_fire(last_fire), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .done(done), .fault(fault),
  .fault_code(fault_code), .cur_idx(byte_idx), .op32_q(op32_q)
);

// File: tb/dtr_store_unit_tb.sv
`timescale 1ns/1ps
module dtr_store_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] opc0 = 8'h0F, opc1 = 8'h01;
  logic [1:0] modrm_mod = 2'b00;
  logic [2:0] modrm_reg = 3'd0;
  logic op32 = 1'b1;
  logic [1:0] cpu_mode = 2'd1, cpl = 2'd0;
  logic ac_en = 1'b0, seg_null = 1'b0, seg_wr = 1'b1, seg_is_ss = 1'b0;
  logic [31:0] seg_limit = 32'hFFFF_FFFF, eff_addr = 32'h100;
  logic [15:0] gdt_limit = 16'h0, idt_limit = 16'h0;
  logic [31:0] gdt_base = 32'h0, idt_base = 32'h0;
  logic busy, mem_valid, mem_ready = 1'b0, done, fault;
  logic [31:0] mem_addr;
  logic [7:0] mem_data;
  logic [2:0] fault_code;

  int checks = 0, failures = 0;
  int ready_pct = 60;
  bit wd_hit = 0;

  always #10 clk = ~clk;

  dtr_store_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opc0(opc0), .opc1(opc1),
    .modrm_mod(modrm_mod), .modrm_reg(modrm_reg), .op32(op32), .cpu_mode(cpu_mode),
    .cpl(cpl), .ac_en(ac_en), .seg_null(seg_null), .seg_wr(seg_wr),
    .seg_is_ss(seg_is_ss), .seg_limit(seg_limit), .eff_addr(eff_addr),
    .gdt_limit(gdt_limit), .gdt_base(gdt_base), .idt_limit(idt_limit),
    .idt_base(idt_base), .busy(busy), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .done(done), .fault(fault),
    .fault_code(fault_code)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Reference model written from the requirement text
  function automatic int ref_code();
    bit prot = (cpu_mode == 2'd1) || (cpu_mode == 2'd3);
    longint top = longint'(eff_addr) + 5;
    if (opc0 != 8'h0F || opc1 != 8'h01) return 1;
    if (modrm_reg > 3'd1 || modrm_mod == 2'b11) return 1;
    if (prot && !seg_wr) return 2;
    if (prot && seg_null && !seg_is_ss) return 2;
    if (top > longint'(seg_limit)) return seg_is_ss ? 3 : 2;
    if (eff_addr[0] && ac_en) begin
      if (cpu_mode == 2'd2) return 4;
      if (prot && cpl == 2'd3) return 4;
    end
    return 0;
  endfunction

  function automatic logic [7:0] ref_byte(input int i);
    logic [15:0] l = modrm_reg[0] ? idt_limit : gdt_limit;
    logic [31:0] b = modrm_reg[0] ? idt_base : gdt_base;
    case (i)
      0: return l[7:0];
      1: return l[15:8];
      2: return b[7:0];
      3: return b[15:8];
      4: return b[23:16];
      default: return op32 ? b[31:24] : 8'h00;
    endcase
  endfunction

  // Runs one instruction with the current inputs; poke issues a second start
  // and scrambles the table registers right after acceptance.
  task automatic run_op(input string tag, input bit poke);
    int e_code = ref_code();
    logic [7:0] e_b[6];
    logic [31:0] e_a = eff_addr;
    logic [7:0] g_d[8];
    logic [31:0] g_a[8];
    int nb = 0;
    bit seen = 0;
    logic g_f = 0;
    logic [2:0] g_c = 0;
    for (int i = 0; i < 6; i++) e_b[i] = ref_byte(i);
    for (int cyc = 0; cyc < 200 && !seen; cyc++) begin
      @(negedge clk);
      start = (cyc == 0) || (poke && cyc == 1);
      if (poke && cyc == 1) begin
        gdt_base = ~gdt_base; idt_base = ~idt_base;
        gdt_limit = ~gdt_limit; idt_limit = ~idt_limit;
        modrm_reg = modrm_reg ^ 3'd1; op32 = ~op32;
      end
      mem_ready = (poke && cyc < 5) ? 1'b0 : (($urandom % 100) < ready_pct);
      #1;
      if (mem_valid && mem_ready && nb < 8) begin
        g_a[nb] = mem_addr; g_d[nb] = mem_data; nb++;
      end
      if (done) begin
        seen = 1; g_f = fault; g_c = fault_code;
      end
    end
    start = 1'b0;
    if (!seen) begin
      wd_hit = 1;
      chk(0, {tag, " watchdog: no done"}, 0, 1);
      return;
    end
    chk(g_f == (e_code != 0), {tag, " R9 fault flag"}, g_f, e_code != 0);
    chk(g_c == 3'(e_code), {tag, " fault_code"}, g_c, e_code);
    chk(nb == ((e_code != 0) ? 0 : 6), {tag, " R11 byte count"}, nb, (e_code != 0) ? 0 : 6);
    if (e_code == 0 && nb == 6) begin
      for (int i = 0; i < 6; i++) begin
        chk(g_a[i] == e_a + 32'(i), {tag, " R11 address"}, g_a[i], e_a + 32'(i));
        chk(g_d[i] == e_b[i], {tag, i < 2 ? " R2 limit byte" : (i == 5 ? " R3/R4 top byte" : " R3 base byte")},
            g_d[i], e_b[i]);
      end
    end
    @(negedge clk);
    #1;
    chk(!done && !busy, {tag, " R12 done pulse then idle"}, {done, busy}, 0);
  endtask

  task automatic set_ok(input logic [2:0] r, input logic s32);
    opc0 = 8'h0F; opc1 = 8'h01; modrm_mod = 2'b00; modrm_reg = r; op32 = s32;
    cpu_mode = 2'd1; cpl = 2'd0; ac_en = 1'b0; seg_null = 1'b0; seg_wr = 1'b1;
    seg_is_ss = 1'b0; seg_limit = 32'h0000_FFFF; eff_addr = 32'h0000_1000;
    gdt_limit = 16'h3A5C; gdt_base = 32'hDEAD_BE0F;
    idt_limit = 16'h07FF; idt_base = 32'h81C4_2290;
  endtask

  task automatic rand_op();
    int p;
    p = $urandom % 100;
    opc0 = (p < 3) ? 8'($urandom) : 8'h0F;
    opc1 = (p >= 3 && p < 6) ? 8'($urandom) : 8'h01;
    modrm_mod = (($urandom % 8) == 0) ? 2'b11 : 2'($urandom % 3);
    modrm_reg = (($urandom % 10) == 0) ? 3'($urandom) : 3'($urandom % 2);
    op32 = 1'($urandom); cpu_mode = 2'($urandom % 3); cpl = 2'($urandom);
    ac_en = 1'($urandom); seg_null = (($urandom % 6) == 0);
    seg_wr = (($urandom % 6) != 0); seg_is_ss = 1'($urandom);
    eff_addr = (($urandom % 10) == 0) ? (32'hFFFF_FFF8 + 32'($urandom % 8)) : 32'($urandom);
    seg_limit = eff_addr + 32'($urandom % 10) - 32'd2;
    if (($urandom % 4) == 0) seg_limit = 32'hFFFF_FFFF;
    gdt_limit = 16'($urandom); gdt_base = $urandom;
    idt_limit = 16'($urandom); idt_base = $urandom;
  endtask

  initial begin
    void'($urandom(32'h5EED_0D7));
    #5;
    chk(!busy && !mem_valid && !done && !fault && fault_code == 0, "R13 reset outputs",
        {busy, mem_valid, done, fault}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    set_ok(3'd0, 1'b1); run_op("R1 R3 global 32-bit", 0);
    set_ok(3'd1, 1'b1); run_op("R1 R3 interrupt 32-bit", 0);
    set_ok(3'd1, 1'b0); run_op("R4 interrupt 16-bit", 0);
    set_ok(3'd0, 1'b0); run_op("R4 global 16-bit", 0);
    set_ok(3'd2, 1'b1); run_op("R1 reg field 2", 0);
    set_ok(3'd0, 1'b1); opc1 = 8'h00; run_op("R1 wrong opcode", 0);
    for (int m = 0; m < 3; m++) begin
      set_ok(3'd0, 1'b1); modrm_mod = 2'b11; cpu_mode = 2'(m); run_op("R5 register dest", 0);
    end
    set_ok(3'd0, 1'b1); seg_null = 1'b1; run_op("R6 null selector prot", 0);
    set_ok(3'd0, 1'b1); seg_null = 1'b1; seg_is_ss = 1'b1; run_op("R6 null on stack seg", 0);
    set_ok(3'd0, 1'b1); seg_wr = 1'b0; run_op("R6 not writable prot", 0);
    set_ok(3'd0, 1'b1); seg_wr = 1'b0; seg_null = 1'b1; cpu_mode = 2'd0; run_op("R6 real mode ignores", 0);
    set_ok(3'd0, 1'b1); seg_wr = 1'b0; cpu_mode = 2'd2; run_op("R6 v86 ignores", 0);
    set_ok(3'd0, 1'b1); seg_limit = 32'h1005; run_op("R7 exact limit", 0);
    set_ok(3'd0, 1'b1); seg_limit = 32'h1004; run_op("R7 over limit GP", 0);
    set_ok(3'd0, 1'b1); seg_limit = 32'h1004; seg_is_ss = 1'b1; run_op("R7 over limit SS", 0);
    set_ok(3'd0, 1'b1); eff_addr = 32'hFFFF_FFFC; seg_limit = 32'hFFFF_FFFF; run_op("R7 wrap", 0);
    set_ok(3'd0, 1'b1); eff_addr = 32'h1001; ac_en = 1'b1; cpl = 2'd3; run_op("R8 prot cpl3", 0);
    set_ok(3'd0, 1'b1); eff_addr = 32'h1001; ac_en = 1'b1; cpl = 2'd0; run_op("R8 prot cpl0", 0);
    set_ok(3'd0, 1'b1); eff_addr = 32'h1001; ac_en = 1'b1; cpu_mode = 2'd2; run_op("R8 v86", 0);
    set_ok(3'd0, 1'b1); eff_addr = 32'h1001; ac_en = 1'b1; cpl = 2'd3; cpu_mode = 2'd0; run_op("R8 real", 0);
    set_ok(3'd0, 1'b1); eff_addr = 32'h1002; ac_en = 1'b1; cpl = 2'd3; run_op("R8 aligned", 0);
    set_ok(3'd0, 1'b1); modrm_mod = 2'b11; seg_wr = 1'b0; run_op("R9 UD over GP", 0);
    set_ok(3'd0, 1'b1); seg_wr = 1'b0; seg_is_ss = 1'b1; seg_limit = 32'h0; run_op("R9 GP over SS", 0);
    set_ok(3'd0, 1'b1); eff_addr = 32'h1001; seg_limit = 32'h1002; seg_is_ss = 1'b1;
    ac_en = 1'b1; cpl = 2'd3; run_op("R9 SS over AC", 0);
    set_ok(3'd1, 1'b0); run_op("R10 start while busy", 1);
    set_ok(3'd0, 1'b1); run_op("R10 start while busy 32", 1);
    ready_pct = 100; set_ok(3'd1, 1'b1); run_op("R11 back to back", 0);
    ready_pct = 25;  set_ok(3'd0, 1'b0); run_op("R11 slow ready", 0);
    ready_pct = 60;

    for (int n = 0; n < 300 && !wd_hit; n++) begin
      rand_op();
      run_op("random", ($urandom % 10) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #3_000_000;
    failures++;
    checks++;
    $display("FAIL global watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule